// File: doc/BRIEF.md
# Quadrature Position Counter

This block tracks the position of an incremental rotary or linear encoder that has two square-wave channels, A and B, a quarter period apart. Each clock it compares the synchronized channel pair with the pair it saw on the previous clock and adjusts a signed position count by -2, -1, 0, +1 or +2. A transition in which both channels flip between two samples cannot show its direction, so the block assumes the edge came from channel A and moves the count by two in place of flagging an error.

After reset the block waits a programmable number of clocks so that any external RC filter on the channels can settle. It then takes the current channel pair as its starting reference and raises `ready`. The host can read the count, read it and clear it in one atomic cycle, or load any 32-bit value. A count change that lands in the same cycle as a clear is kept in the new value, so no motion is lost.

Top module: `quad_pos_counter`

## Requirements
- R1: Each channel passes through SYNC_STAGES flip-flops (default 2). With the default, a change on the channel pins first alters the position at the third rising edge after the change is applied. A read sampled at that edge still returns the earlier value.
- R2: Call the 4-bit transition code {newB, newA, oldB, oldA}, with oldA in bit 0. Codes 1, 7, 8 and 14 add one to the position, and codes 2, 4, 11 and 13 subtract one. So the {B,A} sequence 00, 10, 11, 01 counts upward.
- R3: Codes 3 and 12, where both channels flip from an equal pair, add two. Codes 6 and 9, where both flip from an unequal pair, subtract two.
- R4: Codes 0, 5, 10 and 15, where the channels do not change, leave the position unchanged.
- R5: The position is a 32-bit two's-complement value that wraps. One step up from 0x7FFFFFFF gives 0x80000000, and one step down from 0x80000000 gives 0x7FFFFFFF.
- R6: `ready` is low from reset until the SETTLE_CYCLES-th rising edge after reset is released. It is high from that edge on and never falls until the next reset. At that edge the synchronized pair becomes the reference. Channel activity before it does not move the count.
- R7: A read request captures the position as it stood before the edge. The value appears on `rdData` with `rdValid` high in the following cycle. A read alone does not change the position.
- R8: A read-and-clear request returns the position like a read. The position then becomes the count change of that same cycle, which is 0 when no change occurred.
- R9: A write request loads `wrData` into the position. Any count change in that cycle is dropped, and a write wins over a read-and-clear issued in the same cycle.
- R10: During reset the position is 0 and both `rdValid` and `ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanA | input | 1 | Encoder channel A, asynchronous |
| chanB | input | 1 | Encoder channel B, asynchronous |
| rdReq | input | 1 | Read the position |
| rdClrReq | input | 1 | Read the position and clear it |
| wrReq | input | 1 | Load `wrData` into the position |
| wrData | input | 32 | Value to load |
| rdData | output | 32 | Position captured by the last read |
| rdValid | output | 1 | `rdData` holds a new result this cycle |
| ready | output | 1 | Initial reference captured, counting active |

## Verification
A wrong reference pair or a wrong lookup entry changes the count by the wrong amount on a single transition. The next read, one cycle after its request, returns a value that differs from the model. A synchronizer of the wrong depth shifts every count change by a cycle, so a read aimed at the update edge exposes it. A mishandled collision between a count change and a clear or write leaves a lasting offset that every later read shows. The bench compares `ready`, `rdValid` and `rdData` against a behavioural model on every clock, so each of these faults shows up within one cycle of the read that first sees it.

// File: rtl/quad_pkg.sv
package quad_pkg;

  typedef struct packed {
    logic track;    // reference valid, count every cycle
    logic capture;  // take the first reference pair
    logic load;     // host write
    logic clear;    // host read-and-clear (write absent)
  } quadStrobe_t;

  // transition code {newB, newA, oldB, oldA} -> signed count change
  function automatic logic signed [2:0] stepDelta(input logic [3:0] code);
    logic signed [2:0] d;
    case (code)
      4'd1, 4'd7, 4'd8, 4'd14:  d = 3'sd1;
      4'd2, 4'd4, 4'd11, 4'd13: d = -3'sd1;
      4'd3, 4'd12:              d = 3'sd2;
      4'd6, 4'd9:               d = -3'sd2;
      default:                  d = 3'sd0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanA,
  input  logic        chanB,
  input  logic        rdClrReq,
  input  logic        wrReq,
  output quadStrobe_t strobe,
  output logic [1:0]  abSync,
  output logic        ready
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncA;
  logic [SYNC_STAGES-1:0] syncB;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= chanA;
          syncB <= chanB;
        end
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA <= '0;
          syncB <= '0;
        end else begin
          syncA <= {syncA[SYNC_STAGES-2:0], chanA};
          syncB <= {syncB[SYNC_STAGES-2:0], chanB};
        end
      end
    end
  endgenerate

  assign abSync = {syncB[SYNC_STAGES-1], syncA[SYNC_STAGES-1]};

  logic [CNT_W-1:0] settleCnt;
  logic             readyQ;
  logic             captureNow;

  assign captureNow = !readyQ && (settleCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      readyQ    <= 1'b0;
    end else if (captureNow) begin
      readyQ <= 1'b1;
    end else if (!readyQ) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.track   = readyQ;
    strobe.capture = captureNow;
    strobe.load    = wrReq;
    strobe.clear   = rdClrReq && !wrReq;
  end

  assign ready = readyQ;

endmodule

// File: rtl/quad_datapath.sv
module quad_datapath
  import quad_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  quadStrobe_t      strobe,
  input  logic [1:0]       abSync,
  input  logic [POS_W-1:0] wrData,
  output logic [POS_W-1:0] posNow
);

  logic [1:0]        prevAb;
  logic [3:0]        code;
  logic signed [2:0] rawStep;
  logic [POS_W-1:0]  stepExt;
  logic [POS_W-1:0]  posQ;

  assign code    = {abSync, prevAb};
  assign rawStep = stepDelta(code);
  // no motion is credited before the reference exists
  assign stepExt = strobe.track ? {{(POS_W-3){rawStep[2]}}, rawStep} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAb <= 2'b00;
      posQ   <= '0;
    end else begin
      if (strobe.capture || strobe.track) prevAb <= abSync;
      if (strobe.load)       posQ <= wrData;
      else if (strobe.clear) posQ <= stepExt;
      else                   posQ <= posQ + stepExt;
    end
  end

  assign posNow = posQ;

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import quad_pkg::*;
#(
  parameter int POS_W         = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanA,
  input  logic             chanB,
  input  logic             rdReq,
  input  logic             rdClrReq,
  input  logic             wrReq,
  input  logic [POS_W-1:0] wrData,
  output logic [POS_W-1:0] rdData,
  output logic             rdValid,
  output logic             ready
);

  quadStrobe_t      strobe;
  logic [1:0]       abSync;
  logic [POS_W-1:0] posNow;

  quad_ctrl #(
    .SYNC_STAGES  (SYNC_STAGES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .chanA   (chanA),
    .chanB   (chanB),
    .rdClrReq(rdClrReq),
    .wrReq   (wrReq),
    .strobe  (strobe),
    .abSync  (abSync),
    .ready   (ready)
  );

  quad_datapath #(
    .POS_W(POS_W)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .abSync(abSync),
    .wrData(wrData),
    .posNow(posNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdReq || rdClrReq;
      if (rdReq || rdClrReq) rdData <= posNow;
    end
  end

endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int POS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             rdClrReq,
  input logic             wrReq,
  input logic [POS_W-1:0] wrData,
  input logic [POS_W-1:0] rdData,
  input logic             rdValid,
  input logic             ready,
  input logic [POS_W-1:0] posNow,
  input logic [1:0]       abSync
);

  localparam logic [POS_W-1:0] TWO  = POS_W'(2);
  localparam logic [POS_W-1:0] FOUR = POS_W'(4);

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  assert_no_count_before_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !wrReq && !rdClrReq) |=> posNow == $past(posNow));

  assert_read_returns_old_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || rdClrReq) |=> (rdValid && rdData == $past(posNow)));

  assert_clear_leaves_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdClrReq && !wrReq) |=> ((posNow + TWO) <= FOUR));

  assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> posNow == $past(wrData));

  assert_step_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !wrReq && !rdClrReq) |=> ((posNow - $past(posNow) + TWO) <= FOUR));

  assert_still_inputs_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready) && abSync == $past(abSync) && !wrReq && !rdClrReq)
      |=> posNow == $past(posNow));

endmodule

bind quad_pos_counter quad_pos_counter_chk #(.POS_W(POS_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .rdReq   (rdReq),
  .rdClrReq(rdClrReq),
  .wrReq   (wrReq),
  .wrData  (wrData),
  .rdData  (rdData),
  .rdValid (rdValid),
  .ready   (ready),
  .posNow  (posNow),
  .abSync  (abSync)
);

// File: tb/quad_pos_counter_tb_top.sv
`timescale 1ns/1ps
module quad_pos_counter_tb_top;

  localparam int SETTLE = 16;
  localparam int SYNC   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanA = 1'b0, chanB = 1'b0;
  logic        rdReq = 1'b0, rdClrReq = 1'b0, wrReq = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid, ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curTag = "R10";

  always #10 clk = ~clk;

  quad_pos_counter #(.POS_W(32), .SYNC_STAGES(SYNC), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB),
    .rdReq(rdReq), .rdClrReq(rdClrReq), .wrReq(wrReq), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .ready(ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [1:0]  pipeQ[$];
  int          mEdges;
  bit          mReady;
  logic [1:0]  mPrev;
  logic [31:0] mPos;
  bit          mRdValid;
  logic [31:0] mRdData;

  function automatic int phaseOf(input logic [1:0] ba);
    case (ba)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int moveOf(input logic [1:0] oldBa, input logic [1:0] newBa);
    int diff;
    diff = (phaseOf(newBa) - phaseOf(oldBa) + 4) % 4;
    if (diff == 1) return 1;
    if (diff == 3) return -1;
    if (diff == 2) return (oldBa[0] == oldBa[1]) ? 2 : -2;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ.delete();
      for (int i = 0; i < SYNC; i++) pipeQ.push_back(2'b00);
      mEdges = 0; mReady = 0; mPrev = 2'b00; mPos = '0;
      mRdValid = 0; mRdData = '0;
    end else begin
      logic [1:0] seen;
      int mv;
      pipeQ.push_back({chanB, chanA});
      seen = pipeQ.pop_front();
      mRdValid = rdReq || rdClrReq;
      if (mRdValid) mRdData = mPos;
      mv = 0;
      if (!mReady) begin
        mEdges++;
        if (mEdges == SETTLE) begin
          mReady = 1;
          mPrev = seen;
        end
      end else begin
        mv = moveOf(mPrev, seen);
        mPrev = seen;
      end
      if (wrReq)         mPos = wrData;
      else if (rdClrReq) mPos = 32'(mv);
      else               mPos = mPos + 32'(mv);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6 ready", {31'd0, ready}, {31'd0, mReady});
      check("R7 rdValid", {31'd0, rdValid}, {31'd0, mRdValid});
      if (mRdValid) check({curTag, " rdData"}, rdData, mRdData);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic setBa(input logic [1:0] ba);
    @(negedge clk);
    chanB = ba[1]; chanA = ba[0];
    repeat (3) @(negedge clk);
  endtask

  task automatic readPos(input bit clr, output logic [31:0] v);
    @(negedge clk);
    rdReq = !clr; rdClrReq = clr;
    @(negedge clk);
    rdReq = 0; rdClrReq = 0;
    v = rdData;
  endtask

  task automatic writePos(input logic [31:0] v);
    @(negedge clk);
    wrReq = 1; wrData = v;
    @(negedge clk);
    wrReq = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [1:0] cur;
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 rdValid", {31'd0, rdValid}, 32'd0);
    check("R10 ready", {31'd0, ready}, 32'd0);
    rstN = 1;

    // R6: activity during settle is ignored; reference taken at settle edge
    curTag = "R6";
    chanB = 1; chanA = 0;
    repeat (5) @(negedge clk);
    chanB = 1; chanA = 1;
    repeat (SETTLE + 4) @(negedge clk);
    check("R6 ready high", {31'd0, ready}, 32'd1);
    readPos(0, v);
    check("R6 no count before ready", v, 32'd0);

    // R2: upward steps from 11 -> 01 -> 00 -> 10 -> 11 ... (8 steps)
    curTag = "R2";
    setBa(2'b01); setBa(2'b00); setBa(2'b10); setBa(2'b11);
    setBa(2'b01); setBa(2'b00); setBa(2'b10); setBa(2'b11);
    readPos(0, v);
    check("R2 up 8", v, 32'd8);
    setBa(2'b10); setBa(2'b00); setBa(2'b01);
    readPos(0, v);
    check("R2 down 3", v, 32'd5);

    // R4: holding still
    curTag = "R4";
    repeat (20) @(negedge clk);
    readPos(0, v);
    check("R4 still", v, 32'd5);

    // R3: double transitions, current {B,A} = 01
    curTag = "R3";
    writePos(32'd0);
    setBa(2'b00);            // code 1: +1
    setBa(2'b11);            // code 12: +2
    setBa(2'b00);            // code 3: +2
    setBa(2'b10);            // code 8: +1
    setBa(2'b01);            // code 6: -2
    readPos(0, v);
    check("R3 double moves", v, 32'd4);
    setBa(2'b10);            // code 9: -2
    readPos(0, v);
    check("R3 down 2", v, 32'd2);

    // R5: wrap both ways, current {B,A} = 10
    curTag = "R5";
    writePos(32'h7FFF_FFFF);
    setBa(2'b11);
    readPos(0, v);
    check("R5 wrap up", v, 32'h8000_0000);
    setBa(2'b10);
    readPos(0, v);
    check("R5 wrap down", v, 32'h7FFF_FFFF);

    // R1: latency, current {B,A} = 10 -> 11 is +1
    curTag = "R1";
    writePos(32'd20);
    @(negedge clk); chanB = 1; chanA = 1;
    @(negedge clk); @(negedge clk);
    rdReq = 1;                 // sampled at the third edge: old value
    @(negedge clk);
    v = rdData;
    check("R1 update edge read old", v, 32'd20);
    @(negedge clk);            // second read, sampled one edge later
    rdReq = 0;
    check("R1 next read new", rdData, 32'd21);

    // R9: write collides with a count change; current 11 -> 01 is +1
    curTag = "R9";
    @(negedge clk); chanB = 0; chanA = 1;
    @(negedge clk); @(negedge clk);
    wrReq = 1; wrData = 32'd50;
    @(negedge clk); wrReq = 0;
    readPos(0, v);
    check("R9 write drops step", v, 32'd50);

    // R8: clear collides with a count change; current 01 -> 00 is +1
    curTag = "R8";
    @(negedge clk); chanB = 0; chanA = 0;
    @(negedge clk); @(negedge clk);
    rdClrReq = 1;
    @(negedge clk); rdClrReq = 0;
    check("R8 clear returns old", rdData, 32'd50);
    readPos(0, v);
    check("R8 step kept after clear", v, 32'd1);
    readPos(1, v);
    check("R8 plain clear returns", v, 32'd1);
    readPos(0, v);
    check("R8 cleared to zero", v, 32'd0);

    // R9: write beats clear in the same cycle
    curTag = "R9";
    @(negedge clk);
    wrReq = 1; rdClrReq = 1; wrData = 32'hDEAD_BEEF;
    @(negedge clk);
    wrReq = 0; rdClrReq = 0;
    check("R9 clear same cycle returns", rdData, 32'd0);
    readPos(0, v);
    check("R9 write wins", v, 32'hDEAD_BEEF);

    // mixed random walk, model compared every clock
    curTag = "R2 R3 R7 R8 R9 random";
    cur = 2'b00;
    for (int i = 0; i < 600; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      if (r < 40) cur = {cur[0], ~cur[1]};
      else if (r < 50) cur = ~cur;
      else if (r < 55) cur = {~cur[0], cur[1]};
      chanB = cur[1]; chanA = cur[0];
      rdReq    = ($urandom_range(0, 9) == 0);
      rdClrReq = ($urandom_range(0, 19) == 0);
      wrReq    = ($urandom_range(0, 29) == 0);
      wrData   = $urandom;
    end
    @(negedge clk);
    rdReq = 0; rdClrReq = 0; wrReq = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule